// File: doc/BRIEF.md
# Set-Associative Data Translation Buffer

This block translates 64-bit effective addresses into 56-bit real addresses for a data-side load/store path. Pages are a fixed 4 KiB. The table has 64 sets of 2 ways. Each way holds a valid bit, the upper effective-address bits as a tag, and a full 64-bit page-table entry. A requester presents an address, a virtual-mode flag, a valid strobe and a command flag. One cycle after the request is accepted, the block shows the translated real address, a hit flag with the hit way, the hit way's stored entry, and a translation-valid flag. In real mode the effective address passes straight through and the translation is always valid.

Management requests share the same request path. Bits 11 to 9 of the command address choose the action. If either of bits 11 and 10 is 1, the whole table is flushed. Otherwise, if bit 9 is 1, the data word is loaded as a new entry. Otherwise only the entry that hits is invalidated. Table writes take effect at the end of the compare cycle. A lookup that misses in virtual mode is not stalled: it completes as an error one cycle later.

Completion is reported by a three-state machine. The states are CPL_IDLE, CPL_CMD and CPL_MISS. Every unstalled cycle the machine moves as follows:
- to CPL_CMD when a command is processed;
- to CPL_MISS when a lookup produces an invalid translation;
- to CPL_IDLE in all other cases.

Any state can move to any other state. While the stall input is high, the machine returns to CPL_IDLE. Commands are decoded as CMD_FLUSH, CMD_LOAD and CMD_INVAL; a plain lookup decodes as CMD_NONE.

Top module: `dtlb_xlate`

## Requirements
- R1: A lookup hits only when a valid way in the set selected by EA bits 17:12 holds a tag equal to EA bits 63:18. On a hit, xl_hit is 1 and xl_hit_way gives that way (0 or 1).
- R2: In virtual mode (req_virt=1), xl_ra is PTE bits 55:12 of the hit way concatenated with EA bits 11:0, and xl_pte is that way's full stored 64-bit word.
- R3: In real mode (req_virt=0), xl_ra equals EA bits 55:0 and xl_ok is 1, whether or not the table hits.
- R4: xl_ok is 1 only for a valid request that hits or is in real mode. A non-command request with xl_ok=0 raises miss_err for one cycle, one cycle after its compare cycle.
- R5: A command whose address has bit 11 or bit 10 set clears every valid bit in every set. This applies even when bit 9 is also set.
- R6: A command with bits 11:10 = 00 and bit 9 = 1 writes the tag and the data word into the hitting way on a hit, or into the set's victim way on a miss, and marks that way valid.
- R7: Each set keeps a victim pointer that is 0 after reset. When an unstalled request hits way w in that set, the pointer becomes (w+1) mod 2.
- R8: A command with bits 11:9 = 000 clears the valid bit of the way that hits. If nothing hits, it changes nothing.
- R9: Every processed command raises cmd_done for exactly one cycle, one cycle after its compare cycle. A command never raises miss_err.
- R10: The translation outputs for a request accepted at clock edge N are valid during the cycle that follows edge N.
- R11: While stall_in is 1, the accepted request is held, the table is not written, and neither cmd_done nor miss_err is raised. Once stall_in falls, the held request completes.
- R12: Reset clears all valid bits, all victim pointers and both completion outputs.
- R13: A lookup accepted in the cycle right after a table write to the same set sees the written contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_in | input | 1 | Holds the request pipeline and blocks table writes and completions |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 1 | Request is a management command |
| req_virt | input | 1 | Translate through the table (1) or pass the address through (0) |
| req_ea | input | 64 | Effective address, or command address for commands |
| req_data | input | 64 | Page-table entry word for the load command |
| xl_hit | output | 1 | Valid request matched a table entry |
| xl_hit_way | output | 1 | Index of the highest matching way |
| xl_ok | output | 1 | Translation valid |
| xl_ra | output | 56 | Real address |
| xl_pte | output | 64 | Stored entry of the selected way |
| cmd_done | output | 1 | Command completion pulse |
| miss_err | output | 1 | Error completion pulse for an untranslatable access |

## Verification
Two situations are the hardest to reach from the ports. The first is a write and a read of the same set on the same clock edge. The second is a held request whose completion must be withheld. The bench reaches the first by driving a load command and then, one cycle later, a lookup of the same page, and expects a hit that can only come through the forwarding path. It reaches the second by raising stall_in just after a missing lookup is accepted, while a different request is offered. It then checks that no error appears during the stall, and that the error appears exactly one cycle after the stall is released. Victim-pointer order is observed by placing three pages in one set and watching which older page is lost.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    // Command-address bit positions that select the management action
    localparam int CMD_SEL_HI = 11;
    localparam int CMD_SEL_LO = 9;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_FLUSH,
        CMD_LOAD,
        CMD_INVAL
    } cmd_kind_e;

    typedef enum logic [1:0] {
        CPL_IDLE,
        CPL_CMD,
        CPL_MISS
    } cpl_state_e;

    // sel = {bit 11, bit 10, bit 9}; flush has priority over load
    function automatic cmd_kind_e cmd_decode(input logic [2:0] sel);
        if (sel[2] || sel[1]) begin
            return CMD_FLUSH;
        end else if (sel[0]) begin
            return CMD_LOAD;
        end
        return CMD_INVAL;
    endfunction

endpackage

// File: rtl/dtlb_store.sv
module dtlb_store #(
    parameter int SET_BITS = 6,
    parameter int WAYS     = 2,
    parameter int TAG_W    = 46,
    parameter int PTE_W    = 64,
    localparam int SETS     = 1 << SET_BITS,
    localparam int WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_BITS-1:0]            rd_idx,
    input  logic                           wr_en,
    input  logic                           wr_clear,
    input  logic [SET_BITS-1:0]            wr_idx,
    input  logic [WAY_BITS-1:0]            wr_way,
    input  logic [TAG_W-1:0]               wr_tag,
    input  logic [PTE_W-1:0]               wr_pte,
    input  logic                           flush,
    output logic [WAYS-1:0]                row_vld,
    output logic [WAYS-1:0][TAG_W-1:0]     row_tag,
    output logic [WAYS-1:0][PTE_W-1:0]     row_pte
);

    logic [WAYS-1:0]            vld_q   [SETS];
    logic [WAYS-1:0][TAG_W-1:0] tag_mem [SETS];
    logic [WAYS-1:0][PTE_W-1:0] pte_mem [SETS];

    logic [WAYS-1:0]            nxt_vld;
    logic [WAYS-1:0][TAG_W-1:0] nxt_tag;
    logic [WAYS-1:0][PTE_W-1:0] nxt_pte;

    // Valid bits: reset and flush clear every set at once
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_idx][wr_way] <= ~wr_clear;
        end
    end

    // Tag and entry storage, written only by an entry load
    always_ff @(posedge clk) begin
        if (wr_en && !wr_clear) begin
            tag_mem[wr_idx][wr_way] <= wr_tag;
            pte_mem[wr_idx][wr_way] <= wr_pte;
        end
    end

    // Read port with forwarding of a write landing on the same edge
    always_comb begin
        nxt_vld = vld_q[rd_idx];
        nxt_tag = tag_mem[rd_idx];
        nxt_pte = pte_mem[rd_idx];
        if (wr_en && (wr_idx == rd_idx)) begin
            nxt_vld[wr_way] = ~wr_clear;
            if (!wr_clear) begin
                nxt_tag[wr_way] = wr_tag;
                nxt_pte[wr_way] = wr_pte;
            end
        end
        if (flush) begin
            nxt_vld = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_vld <= '0;
        end else begin
            row_vld <= nxt_vld;
        end
    end

    always_ff @(posedge clk) begin
        row_tag <= nxt_tag;
        row_pte <= nxt_pte;
    end

endmodule

// File: rtl/dtlb_victim.sv
module dtlb_victim #(
    parameter int SET_BITS = 6,
    parameter int WAYS     = 2,
    localparam int SETS     = 1 << SET_BITS,
    localparam int WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic [SET_BITS-1:0] upd_idx,
    input  logic [WAY_BITS-1:0] upd_way,
    input  logic [SET_BITS-1:0] rd_idx,
    output logic [WAY_BITS-1:0] victim
);

    logic [SETS-1:0][WAY_BITS-1:0] ptr_all;
    logic [WAY_BITS-1:0]           ptr_nxt;

    // Point just past the way that was used
    assign ptr_nxt = (upd_way == WAY_BITS'(WAYS - 1)) ? '0 : upd_way + 1'b1;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAY_BITS-1:0] ptr_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ptr_q <= '0;
            end else if (upd_en && (upd_idx == SET_BITS'(s))) begin
                ptr_q <= ptr_nxt;
            end
        end
        assign ptr_all[s] = ptr_q;
    end

    assign victim = ptr_all[rd_idx];

endmodule

// File: rtl/dtlb_match.sv
module dtlb_match #(
    parameter int WAYS    = 2,
    parameter int TAG_W   = 46,
    parameter int PTE_W   = 64,
    parameter int RA_W    = 56,
    parameter int PG_BITS = 12,
    localparam int WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                       req_valid,
    input  logic                       virt,
    input  logic [TAG_W-1:0]           ea_tag,
    input  logic [PG_BITS-1:0]         ea_off,
    input  logic [RA_W-1:0]            ea_real,
    input  logic [WAYS-1:0]            row_vld,
    input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
    input  logic [WAYS-1:0][PTE_W-1:0] row_pte,
    output logic                       hit,
    output logic [WAY_BITS-1:0]        hit_way,
    output logic [PTE_W-1:0]           hit_pte,
    output logic [RA_W-1:0]            ra,
    output logic                       ok
);

    logic [WAYS-1:0] way_match;
    logic            any_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_match[w] = row_vld[w] && (row_tag[w] == ea_tag);
    end

    // Highest-numbered matching way wins
    always_comb begin
        hit_way   = '0;
        any_match = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (way_match[w]) begin
                hit_way   = WAY_BITS'(w);
                any_match = 1'b1;
            end
        end
    end

    assign hit_pte = row_pte[hit_way];
    assign hit     = req_valid && any_match;
    assign ok      = req_valid && (any_match || !virt);
    assign ra      = virt ? {hit_pte[RA_W-1:PG_BITS], ea_off} : ea_real;

endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
    import dtlb_pkg::*;
#(
    parameter int EA_W     = 64,
    parameter int RA_W     = 56,
    parameter int PG_BITS  = 12,
    parameter int SET_BITS = 6,
    parameter int WAYS     = 2,
    localparam int TAG_W    = EA_W - PG_BITS - SET_BITS,
    localparam int PTE_W    = EA_W,
    localparam int WAY_BITS = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stall_in,
    input  logic                req_valid,
    input  logic                req_cmd,
    input  logic                req_virt,
    input  logic [EA_W-1:0]     req_ea,
    input  logic [PTE_W-1:0]    req_data,
    output logic                xl_hit,
    output logic [WAY_BITS-1:0] xl_hit_way,
    output logic                xl_ok,
    output logic [RA_W-1:0]     xl_ra,
    output logic [PTE_W-1:0]    xl_pte,
    output logic                cmd_done,
    output logic                miss_err
);

    // Request stage
    logic             r0_valid;
    logic             r0_cmd;
    logic             r0_virt;
    logic [EA_W-1:0]  r0_ea;
    logic [PTE_W-1:0] r0_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r0_valid <= 1'b0;
        end else if (!stall_in) begin
            r0_valid <= req_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!stall_in) begin
            r0_cmd  <= req_cmd;
            r0_virt <= req_virt;
            r0_ea   <= req_ea;
            r0_data <= req_data;
        end
    end

    logic [SET_BITS-1:0] r0_idx;
    logic [SET_BITS-1:0] rd_idx;
    logic [TAG_W-1:0]    r0_tag;

    assign r0_idx = r0_ea[PG_BITS +: SET_BITS];
    assign r0_tag = r0_ea[EA_W-1 -: TAG_W];
    // While stalled, read the held request's set again
    assign rd_idx = stall_in ? r0_idx : req_ea[PG_BITS +: SET_BITS];

    // Table storage and compare
    logic                       wr_en;
    logic                       wr_clear;
    logic [WAY_BITS-1:0]        wr_way;
    logic                       flush;
    logic [WAYS-1:0]            row_vld;
    logic [WAYS-1:0][TAG_W-1:0] row_tag;
    logic [WAYS-1:0][PTE_W-1:0] row_pte;
    logic [WAY_BITS-1:0]        victim;

    dtlb_store #(
        .SET_BITS (SET_BITS),
        .WAYS     (WAYS),
        .TAG_W    (TAG_W),
        .PTE_W    (PTE_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_clear (wr_clear),
        .wr_idx   (r0_idx),
        .wr_way   (wr_way),
        .wr_tag   (r0_tag),
        .wr_pte   (r0_data),
        .flush    (flush),
        .row_vld  (row_vld),
        .row_tag  (row_tag),
        .row_pte  (row_pte)
    );

    dtlb_match #(
        .WAYS    (WAYS),
        .TAG_W   (TAG_W),
        .PTE_W   (PTE_W),
        .RA_W    (RA_W),
        .PG_BITS (PG_BITS)
    ) match_i (
        .req_valid (r0_valid),
        .virt      (r0_virt),
        .ea_tag    (r0_tag),
        .ea_off    (r0_ea[PG_BITS-1:0]),
        .ea_real   (r0_ea[RA_W-1:0]),
        .row_vld   (row_vld),
        .row_tag   (row_tag),
        .row_pte   (row_pte),
        .hit       (xl_hit),
        .hit_way   (xl_hit_way),
        .hit_pte   (xl_pte),
        .ra        (xl_ra),
        .ok        (xl_ok)
    );

    dtlb_victim #(
        .SET_BITS (SET_BITS),
        .WAYS     (WAYS)
    ) victim_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (xl_hit && !stall_in),
        .upd_idx (r0_idx),
        .upd_way (xl_hit_way),
        .rd_idx  (r0_idx),
        .victim  (victim)
    );

    // Command decode and table update at the end of the compare cycle
    cmd_kind_e cmd_kind;
    logic      cmd_fire;
    logic      miss_fire;

    assign cmd_kind  = r0_cmd ? cmd_decode(r0_ea[CMD_SEL_HI:CMD_SEL_LO]) : CMD_NONE;
    assign cmd_fire  = r0_valid && r0_cmd && !stall_in;
    assign miss_fire = r0_valid && !r0_cmd && !xl_ok && !stall_in;

    always_comb begin
        wr_en    = 1'b0;
        wr_clear = 1'b0;
        wr_way   = xl_hit_way;
        flush    = 1'b0;
        if (cmd_fire) begin
            unique case (cmd_kind)
                CMD_FLUSH: flush = 1'b1;
                CMD_LOAD: begin
                    wr_en  = 1'b1;
                    wr_way = xl_hit ? xl_hit_way : victim;
                end
                CMD_INVAL: begin
                    wr_en    = xl_hit;
                    wr_clear = 1'b1;
                end
                CMD_NONE: ;
            endcase
        end
    end

    // Completion state machine: state register
    cpl_state_e cpl_q;
    cpl_state_e cpl_nxt;

    always_comb begin
        if (cmd_fire) begin
            cpl_nxt = CPL_CMD;
        end else if (miss_fire) begin
            cpl_nxt = CPL_MISS;
        end else begin
            cpl_nxt = CPL_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpl_q <= CPL_IDLE;
        end else begin
            cpl_q <= cpl_nxt;
        end
    end

    // Completion state machine: outputs
    always_comb begin
        cmd_done = 1'b0;
        miss_err = 1'b0;
        unique case (cpl_q)
            CPL_IDLE: ;
            CPL_CMD:  cmd_done = 1'b1;
            CPL_MISS: miss_err = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk #(
    parameter int EA_W = 64,
    parameter int RA_W = 56
) (
    input logic            clk,
    input logic            rst_n,
    input logic            stall_in,
    input logic            r0_valid,
    input logic            r0_cmd,
    input logic            r0_virt,
    input logic [EA_W-1:0] r0_ea,
    input logic            xl_hit,
    input logic            xl_ok,
    input logic [RA_W-1:0] xl_ra,
    input logic            cmd_done,
    input logic            miss_err
);

    p_real_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_valid && !r0_virt) |-> (xl_ok && (xl_ra == r0_ea[RA_W-1:0])));

    p_ok_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_ok || xl_hit) |-> r0_valid);

    p_miss_reports_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_valid && !r0_cmd && !xl_ok && !stall_in) |=> miss_err);

    p_cmd_completes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r0_valid && r0_cmd && !stall_in) |=> (cmd_done && !miss_err));

    p_done_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_done && miss_err));

    p_stall_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall_in |=> (!cmd_done && !miss_err));

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall_in |=> ($stable(xl_hit) && $stable(xl_ok)));

    p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cmd_done && !miss_err));

endmodule

bind dtlb_xlate dtlb_xlate_chk #(
    .EA_W (EA_W),
    .RA_W (RA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_in (stall_in),
    .r0_valid (r0_valid),
    .r0_cmd   (r0_cmd),
    .r0_virt  (r0_virt),
    .r0_ea    (r0_ea),
    .xl_hit   (xl_hit),
    .xl_ok    (xl_ok),
    .xl_ra    (xl_ra),
    .cmd_done (cmd_done),
    .miss_err (miss_err)
);

// File: tb/dtlb_xlate_tb_top.sv
module dtlb_xlate_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_in = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_cmd = 1'b0;
    logic        req_virt = 1'b0;
    logic [63:0] req_ea = '0;
    logic [63:0] req_data = '0;
    logic        xl_hit;
    logic [0:0]  xl_hit_way;
    logic        xl_ok;
    logic [55:0] xl_ra;
    logic [63:0] xl_pte;
    logic        cmd_done;
    logic        miss_err;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_P / 2) clk = ~clk;

    dtlb_xlate dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .stall_in   (stall_in),
        .req_valid  (req_valid),
        .req_cmd    (req_cmd),
        .req_virt   (req_virt),
        .req_ea     (req_ea),
        .req_data   (req_data),
        .xl_hit     (xl_hit),
        .xl_hit_way (xl_hit_way),
        .xl_ok      (xl_ok),
        .xl_ra      (xl_ra),
        .xl_pte     (xl_pte),
        .cmd_done   (cmd_done),
        .miss_err   (miss_err)
    );

    typedef struct packed {
        logic        cmd;
        logic        virt;
        logic [63:0] ea;
        logic [63:0] data;
        logic        e_hit;
        logic        e_way;
        logic        e_ok;
        logic        chk_ra;
        logic [55:0] e_ra;
        logic        e_miss;
        logic        e_done;
    } vec_t;

    localparam int NV = 27;
    // Pages: A=0x403, B=0x443, C=0x483 share set 3; D=0x001 in set 1
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 64'hFFFF_1234_5678_9ABC, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1, 56'hFF_1234_5678_9ABC, 1'b0, 1'b0}, // R3 real pass
        '{1'b0, 1'b1, 64'h0000_0000_0040_3123, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 56'h0, 1'b1, 1'b0},                 // R4 miss
        '{1'b1, 1'b0, 64'h0000_0000_0040_3200, 64'h8000_0012_3456_7007, 1'b0, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1}, // R6 load A way0
        '{1'b0, 1'b1, 64'h0000_0000_0040_3123, 64'h0, 1'b1, 1'b0, 1'b1, 1'b1, 56'h00_0012_3456_7123, 1'b0, 1'b0}, // R2 R1
        '{1'b1, 1'b0, 64'h0000_0000_0044_3200, 64'h0000_0000_ABCD_E000, 1'b0, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1}, // R7 load B way1
        '{1'b0, 1'b1, 64'h0000_0000_0044_3FFF, 64'h0, 1'b1, 1'b1, 1'b1, 1'b1, 56'h00_0000_ABCD_EFFF, 1'b0, 1'b0}, // R7 B in way1
        '{1'b0, 1'b1, 64'h0000_0000_0040_3000, 64'h0, 1'b1, 1'b0, 1'b1, 1'b1, 56'h00_0012_3456_7000, 1'b0, 1'b0}, // R1
        '{1'b1, 1'b0, 64'h0000_0000_0048_3200, 64'h0000_0000_0005_5000, 1'b0, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1}, // R7 C evicts B
        '{1'b0, 1'b1, 64'h0000_0000_0044_3FFF, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 56'h0, 1'b1, 1'b0},                 // R7 B gone
        '{1'b0, 1'b1, 64'h0000_0000_0048_3ABC, 64'h0, 1'b1, 1'b1, 1'b1, 1'b1, 56'h00_0000_0005_5ABC, 1'b0, 1'b0}, // R2
        '{1'b1, 1'b0, 64'h0000_0000_0040_3200, 64'h0000_0000_0077_7000, 1'b1, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1}, // R6 rewrite hit way
        '{1'b0, 1'b1, 64'h0000_0000_0040_3010, 64'h0, 1'b1, 1'b0, 1'b1, 1'b1, 56'h00_0000_0077_7010, 1'b0, 1'b0}, // R6
        '{1'b1, 1'b0, 64'h0000_0000_0040_3000, 64'h0, 1'b1, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1},                 // R8 invalidate A
        '{1'b0, 1'b1, 64'h0000_0000_0040_3123, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 56'h0, 1'b1, 1'b0},                 // R8 A gone
        '{1'b0, 1'b1, 64'h0000_0000_0048_3000, 64'h0, 1'b1, 1'b1, 1'b1, 1'b1, 56'h00_0000_0005_5000, 1'b0, 1'b0}, // R8 C kept
        '{1'b0, 1'b0, 64'h0000_0000_0048_3ABC, 64'h0, 1'b1, 1'b1, 1'b1, 1'b1, 56'h00_0000_0048_3ABC, 1'b0, 1'b0}, // R3 hit, real addr
        '{1'b1, 1'b0, 64'h0000_0000_0000_0400, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1},                 // R5 flush bit10
        '{1'b0, 1'b1, 64'h0000_0000_0048_3ABC, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 56'h0, 1'b1, 1'b0},                 // R5 C gone
        '{1'b1, 1'b0, 64'h0000_0000_0000_1200, 64'h0000_0000_0099_9000, 1'b0, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1}, // R6 load D way0
        '{1'b0, 1'b1, 64'h0000_0000_0000_1234, 64'h0, 1'b1, 1'b0, 1'b1, 1'b1, 56'h00_0000_0099_9234, 1'b0, 1'b0}, // R2
        '{1'b1, 1'b0, 64'h0000_0000_0000_1A00, 64'h0000_0000_0011_1000, 1'b1, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1}, // R5 bit11+bit9
        '{1'b0, 1'b1, 64'h0000_0000_0000_1234, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 56'h0, 1'b1, 1'b0},                 // R5 flush won
        '{1'b1, 1'b0, 64'h0000_0000_0000_1200, 64'h0000_0000_0099_9000, 1'b0, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1}, // R7 victim way1
        '{1'b0, 1'b1, 64'h0000_0000_0000_1008, 64'h0, 1'b1, 1'b1, 1'b1, 1'b1, 56'h00_0000_0099_9008, 1'b0, 1'b0}, // R7
        '{1'b1, 1'b0, 64'h0000_0000_0004_1000, 64'h0, 1'b0, 1'b0, 1'b1, 1'b0, 56'h0, 1'b0, 1'b1},                 // R8 miss, no effect
        '{1'b0, 1'b1, 64'h0000_0000_0000_1008, 64'h0, 1'b1, 1'b1, 1'b1, 1'b1, 56'h00_0000_0099_9008, 1'b0, 1'b0}, // R8 D kept
        '{1'b0, 1'b1, 64'h8000_0000_0000_1008, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 56'h0, 1'b1, 1'b0}                  // R1 top tag bit
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic drive(input logic cmd, input logic virt, input logic [63:0] ea,
                         input logic [63:0] data);
        req_valid = 1'b1;
        req_cmd   = cmd;
        req_virt  = virt;
        req_ea    = ea;
        req_data  = data;
    endtask

    task automatic idle();
        req_valid = 1'b0;
        req_cmd   = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk("R12 hit after reset", 64'(xl_hit), 64'd0);
        chk("R12 ok after reset", 64'(xl_ok), 64'd0);
        chk("R12 cmd_done after reset", 64'(cmd_done), 64'd0);
        chk("R12 miss_err after reset", 64'(miss_err), 64'd0);

        // Vector table, one request every two cycles (R10 timing)
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].cmd, VECS[i].virt, VECS[i].ea, VECS[i].data);
            @(negedge clk);
            idle();
            chk($sformatf("R1 R10 vec%0d hit", i), 64'(xl_hit), 64'(VECS[i].e_hit));
            if (VECS[i].e_hit) begin
                chk($sformatf("R1 vec%0d way", i), 64'(xl_hit_way), 64'(VECS[i].e_way));
            end
            chk($sformatf("R4 vec%0d ok", i), 64'(xl_ok), 64'(VECS[i].e_ok));
            if (VECS[i].chk_ra) begin
                chk($sformatf("R2 R3 vec%0d ra", i), 64'(xl_ra), 64'(VECS[i].e_ra));
            end
            @(negedge clk);
            chk($sformatf("R4 vec%0d miss_err", i), 64'(miss_err), 64'(VECS[i].e_miss));
            chk($sformatf("R9 vec%0d cmd_done", i), 64'(cmd_done), 64'(VECS[i].e_done));
        end

        // R13 lookup right after a write to the same set (page 0x005, set 5)
        drive(1'b1, 1'b0, 64'h0000_0000_0000_5200, 64'h0000_0000_0ABC_D000);
        @(negedge clk);
        drive(1'b0, 1'b1, 64'h0000_0000_0000_5456, 64'h0);
        @(negedge clk);
        idle();
        chk("R13 forwarded hit", 64'(xl_hit), 64'd1);
        chk("R13 forwarded way", 64'(xl_hit_way), 64'd0);
        chk("R13 forwarded ra", 64'(xl_ra), 64'h0000_0000_0ABC_D456);
        chk("R2 full stored entry", xl_pte, 64'h0000_0000_0ABC_D000);
        chk("R9 load completes", 64'(cmd_done), 64'd1);
        @(negedge clk);
        chk("R9 single pulse", 64'(cmd_done), 64'd0);
        chk("R4 hit gives no error", 64'(miss_err), 64'd0);

        // R11 stall holds a missing lookup and withholds its error
        drive(1'b0, 1'b1, 64'h0000_0000_0000_9000, 64'h0);
        @(negedge clk);
        stall_in = 1'b1;
        drive(1'b0, 1'b1, 64'h0000_0000_0000_5456, 64'h0);
        chk("R11 held miss ok", 64'(xl_ok), 64'd0);
        @(negedge clk);
        chk("R11 no error during stall", 64'(miss_err), 64'd0);
        chk("R11 request held", 64'(xl_hit), 64'd0);
        chk("R11 still untranslated", 64'(xl_ok), 64'd0);
        stall_in = 1'b0;
        idle();
        @(negedge clk);
        chk("R11 error after release", 64'(miss_err), 64'd1);
        @(negedge clk);
        chk("R11 error single pulse", 64'(miss_err), 64'd0);

        // R11 a stalled load command does not write until released
        drive(1'b1, 1'b0, 64'h0000_0000_0000_7200, 64'h0000_0000_0000_4000);
        @(negedge clk);
        stall_in = 1'b1;
        idle();
        @(negedge clk);
        chk("R11 no cmd_done during stall", 64'(cmd_done), 64'd0);
        stall_in = 1'b0;
        @(negedge clk);
        chk("R11 cmd_done after release", 64'(cmd_done), 64'd1);
        drive(1'b0, 1'b1, 64'h0000_0000_0000_7ABC, 64'h0);
        @(negedge clk);
        idle();
        chk("R11 released load visible", 64'(xl_ra), 64'h0000_0000_0000_4ABC);

        // R12 reset in mid-run clears valid bits and victim pointers
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R12 cmd_done in reset", 64'(cmd_done), 64'd0);
        chk("R12 miss_err in reset", 64'(miss_err), 64'd0);
        @(negedge clk);
        drive(1'b0, 1'b1, 64'h0000_0000_0000_5456, 64'h0);
        @(negedge clk);
        idle();
        chk("R12 entry cleared", 64'(xl_hit), 64'd0);
        @(negedge clk);
        chk("R12 cleared entry faults", 64'(miss_err), 64'd1);
        // set 5 pointer was 1 before reset; after reset a load must use way 0
        drive(1'b1, 1'b0, 64'h0000_0000_0000_5200, 64'h0000_0000_0000_3000);
        @(negedge clk);
        idle();
        @(negedge clk);
        drive(1'b0, 1'b1, 64'h0000_0000_0000_5001, 64'h0);
        @(negedge clk);
        idle();
        chk("R12 R7 victim pointer reset", 64'(xl_hit_way), 64'd0);
        chk("R12 reloaded ra", 64'(xl_ra), 64'h0000_0000_0000_3001);
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule